// File: doc/BRIEF.md
# Prescaled Modulo Alarm Timer

This block is a memory-mapped up-counter for alarm and periodic-event generation. A clock-source select picks what advances it: nothing, every system clock, or an external fixed-frequency tick-enable. A power-of-two prescaler then divides that source. The counter is 16 bits wide. It is reloaded from a programmable initial value and climbs until it reaches a programmable modulo value.

The tick after the counter reaches the modulo value reloads it from the initial-value register and raises a sticky overflow flag. An enable bit routes this flag to the interrupt output. Software arms an alarm in four steps: write the modulo value, write any value to the count register to restart from the initial value, select a source, and enable the interrupt. The flag is cleared by reading status and then writing zero to the flag bit.

The bus is a single-cycle register port. Writes take effect at the clock edge on which `busWrEn` is high. Read data is combinational from `busAddr`.

Top module: `modulo_alarm_timer`

## Requirements
- R1: After reset the count reads 0, the status/control register reads 0, the modulo register reads 0xFFFF, the initial-value register reads 0, and `irq` is low.
- R2: On each prescaled tick the count increments by one. On the tick where the count equals the modulo value, the count is instead loaded from the initial-value register.
- R3: The overflow flag (status bit 7) is set only on the tick that moves the count from the modulo value to the initial value. With modulo N-1 and initial value 0, the first flag comes N ticks after a reload.
- R4: A bus write of any data to the count register (offset 0x04) loads the count from the initial-value register. This takes priority over a tick in the same cycle, and the written data is ignored.
- R5: The count, modulo and initial-value registers hold 16 bits. Bits 31:16 read as zero and ignore writes.
- R6: A prescaler field value p (status bits 2:0) yields one tick every 2^p source pulses. The prescaler restarts when the clock source is stopped or when a write changes p.
- R7: Clock-select (status bits 4:3) chooses the source: 0 and 3 stop counting, 1 counts every clock, and 2 counts cycles where `fixedTickEn` is high.
- R8: `irq` is high exactly when the overflow flag and the interrupt-enable bit (status bit 6) are both set.
- R9: The flag clears only when a status write with bit 7 = 0 follows a status read that saw the flag set. A status write with bit 7 = 1, or a write of 0 without a prior read, leaves the flag set. Every status write uses up the read.
- R10: If an overflow occurs on the same edge as a valid clear, the flag stays set.
- R11: The registers sit at offsets 0x00 (status/control), 0x04 (count), 0x08 (modulo) and 0x4C (initial value). Any other offset reads zero and ignores writes.
- R12: If the initial value exceeds the modulo value, the count rises to 0xFFFF. The next tick then loads the initial value and sets the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 8 | Register byte offset |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busRdEn | input | 1 | Read strobe, used to arm the flag clear |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for `busAddr` |
| fixedTickEn | input | 1 | Fixed-frequency tick enable for clock-select 2 |
| irq | output | 1 | Overflow interrupt |

## Verification
Wrap behaviour is tried with the plain case (initial value 0, small modulo) and with an initial value above the modulo. These two runs tell apart a wrap on modulo match from a wrap at the all-ones count.

The prescaler is run at several field values, with a field change mid-run, and with a sparse fixed-tick pattern. This separates division by 2^p, prescaler restart, and source gating.

Flag clearing is tried as a write without a read, as a write of one, as a proper read-then-zero, and timed to land on a fresh overflow. Each case gives a different sticky outcome.

// File: rtl/alarm_timer_pkg.sv
package alarm_timer_pkg;
  localparam logic [7:0] OFF_CTRL  = 8'h00;
  localparam logic [7:0] OFF_COUNT = 8'h04;
  localparam logic [7:0] OFF_MOD   = 8'h08;
  localparam logic [7:0] OFF_INIT  = 8'h4C;

  typedef enum logic [1:0] {
    SRC_OFF   = 2'd0,
    SRC_SYS   = 2'd1,
    SRC_FIXED = 2'd2,
    SRC_HALT  = 2'd3
  } srcSel_t;

  typedef struct packed {
    logic tick;
    logic reload;
    logic wrMod;
    logic wrInit;
  } tmrStrobe_t;
endpackage

// File: rtl/alarm_timer_ctrl.sv
module alarm_timer_ctrl
  import alarm_timer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter int PS_W   = 3,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              fixedTickEn,
  input  logic              wrapPulse,
  input  logic [CNT_W-1:0]  countVal,
  input  logic [CNT_W-1:0]  modVal,
  input  logic [CNT_W-1:0]  initVal,
  output tmrStrobe_t        strobe,
  output logic [DATA_W-1:0] busRdata,
  output logic              irq,
  output logic              flagOut,
  output logic              irqEnable,
  output srcSel_t           clkSel
);
  localparam int DIV_W    = (1 << PS_W) - 1;
  localparam int SEL_LSB  = PS_W;
  localparam int IE_BIT   = PS_W + 3;
  localparam int FLAG_BIT = PS_W + 4;

  logic [PS_W-1:0]  psField;
  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] divLimit;
  logic             flagBit;
  logic             clrArmed;
  logic             hitCtrl, hitCount, hitMod, hitInit;
  logic             wrCtrl, rdCtrl, stopped, srcPulse, psChange, clrFlag;

  assign hitCtrl  = busAddr == ADDR_W'(OFF_CTRL);
  assign hitCount = busAddr == ADDR_W'(OFF_COUNT);
  assign hitMod   = busAddr == ADDR_W'(OFF_MOD);
  assign hitInit  = busAddr == ADDR_W'(OFF_INIT);
  assign wrCtrl   = busWrEn & hitCtrl;
  assign rdCtrl   = busRdEn & hitCtrl;

  assign stopped  = (clkSel == SRC_OFF) | (clkSel == SRC_HALT);
  assign srcPulse = (clkSel == SRC_SYS) | ((clkSel == SRC_FIXED) & fixedTickEn);
  assign divLimit = ~({DIV_W{1'b1}} << psField);
  assign psChange = wrCtrl & (busWdata[PS_W-1:0] != psField);
  assign clrFlag  = wrCtrl & clrArmed & ~busWdata[FLAG_BIT];

  assign strobe.tick   = srcPulse & (divCnt == divLimit);
  assign strobe.reload = busWrEn & hitCount;
  assign strobe.wrMod  = busWrEn & hitMod;
  assign strobe.wrInit = busWrEn & hitInit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      psField   <= '0;
      clkSel    <= SRC_OFF;
      irqEnable <= 1'b0;
    end else if (wrCtrl) begin
      psField   <= busWdata[PS_W-1:0];
      clkSel    <= srcSel_t'(busWdata[SEL_LSB +: 2]);
      irqEnable <= busWdata[IE_BIT];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    divCnt <= '0;
    else if (stopped || psChange) divCnt <= '0;
    else if (srcPulse)            divCnt <= strobe.tick ? '0 : divCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagBit  <= 1'b0;
      clrArmed <= 1'b0;
    end else begin
      flagBit <= wrapPulse | (flagBit & ~clrFlag);
      if (wrCtrl)                clrArmed <= 1'b0;
      else if (rdCtrl && flagBit) clrArmed <= 1'b1;
    end
  end

  always_comb begin
    busRdata = '0;
    if (hitCtrl) begin
      busRdata[PS_W-1:0]       = psField;
      busRdata[SEL_LSB +: 2]   = clkSel;
      busRdata[IE_BIT]         = irqEnable;
      busRdata[FLAG_BIT]       = flagBit;
    end else if (hitCount) busRdata[CNT_W-1:0] = countVal;
    else if (hitMod)       busRdata[CNT_W-1:0] = modVal;
    else if (hitInit)      busRdata[CNT_W-1:0] = initVal;
  end

  assign flagOut = flagBit;
  assign irq     = flagBit & irqEnable;
endmodule

// File: rtl/alarm_timer_dp.sv
module alarm_timer_dp
  import alarm_timer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  tmrStrobe_t        strobe,
  input  logic [DATA_W-1:0] busWdata,
  output logic [CNT_W-1:0]  countVal,
  output logic [CNT_W-1:0]  modVal,
  output logic [CNT_W-1:0]  initVal,
  output logic              wrapPulse
);
  logic atWrap;

  assign atWrap    = (countVal == modVal) | (countVal == {CNT_W{1'b1}});
  assign wrapPulse = strobe.tick & ~strobe.reload & atWrap;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              countVal <= '0;
    else if (strobe.reload) countVal <= initVal;
    else if (strobe.tick)   countVal <= atWrap ? initVal : countVal + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modVal  <= '1;
      initVal <= '0;
    end else begin
      if (strobe.wrMod)  modVal  <= busWdata[CNT_W-1:0];
      if (strobe.wrInit) initVal <= busWdata[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/modulo_alarm_timer.sv
module modulo_alarm_timer
  import alarm_timer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter int PS_W   = 3,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              fixedTickEn,
  output logic              irq
);
  tmrStrobe_t       strobe;
  logic [CNT_W-1:0] countVal, modVal, initVal;
  logic             wrapPulse, ctrlFlag, irqEnable;
  srcSel_t          clkSel;

  alarm_timer_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .PS_W(PS_W), .CNT_W(CNT_W)) ctrlU (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busWdata(busWdata), .fixedTickEn(fixedTickEn), .wrapPulse(wrapPulse),
    .countVal(countVal), .modVal(modVal), .initVal(initVal), .strobe(strobe),
    .busRdata(busRdata), .irq(irq), .flagOut(ctrlFlag), .irqEnable(irqEnable),
    .clkSel(clkSel)
  );

  alarm_timer_dp #(.DATA_W(DATA_W), .CNT_W(CNT_W)) dpU (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busWdata(busWdata),
    .countVal(countVal), .modVal(modVal), .initVal(initVal), .wrapPulse(wrapPulse)
  );
endmodule

// File: rtl/alarm_timer_checker.sv
module alarm_timer_checker
  import alarm_timer_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrEn,
  input logic              busRdEn,
  input logic [DATA_W-1:0] busRdata,
  input logic              irq,
  input logic              ctrlFlag,
  input logic              irqEnable,
  input srcSel_t           clkSel,
  input tmrStrobe_t        strobe,
  input logic [CNT_W-1:0]  countVal,
  input logic [CNT_W-1:0]  modVal,
  input logic [CNT_W-1:0]  initVal
);
  logic ctrlWrite;
  assign ctrlWrite = busWrEn && (busAddr == ADDR_W'(OFF_CTRL));

  AST_RELOAD_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.reload |=> countVal == $past(initVal)); // R4

  AST_WRAP_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.tick && !strobe.reload && countVal == modVal) |=> countVal == $past(initVal)); // R2

  AST_STEP_UP: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.tick && !strobe.reload && countVal != modVal && countVal != '1)
      |=> countVal == $past(countVal) + 1'b1); // R2

  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.tick && !strobe.reload && countVal == modVal) |=> ctrlFlag); // R3

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlFlag && !ctrlWrite) |=> ctrlFlag); // R9

  AST_NO_TICK_STOPPED: assert property (@(posedge clk) disable iff (!rstN)
    (clkSel == SRC_OFF || clkSel == SRC_HALT) |-> !strobe.tick); // R7

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    !irqEnable |-> !irq); // R8

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && busAddr == ADDR_W'(OFF_COUNT)) |-> busRdata[DATA_W-1:CNT_W] == '0); // R5
endmodule

bind modulo_alarm_timer alarm_timer_checker #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn), .busRdEn(busRdEn),
  .busRdata(busRdata), .irq(irq), .ctrlFlag(ctrlFlag), .irqEnable(irqEnable),
  .clkSel(clkSel), .strobe(strobe), .countVal(countVal), .modVal(modVal), .initVal(initVal)
);

// File: tb/modulo_alarm_timer_test.sv
module modulo_alarm_timer_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic        busRdEn = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        fixedTickEn = 1'b0;
  logic        irq;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // reference model state
  int mCnt, mMod, mInit, mPs, mSel, mIe, mFlag, mArm, mDiv;

  modulo_alarm_timer uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busWdata(busWdata), .busRdata(busRdata), .fixedTickEn(fixedTickEn), .irq(irq)
  );

  always #4 clk = ~clk;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    fixedTickEn <= (cyc % 3) == 0;
  end

  function automatic int ctrlWord(int ps, int sel, int ie, int fl);
    return ps | (sel << 3) | (ie << 6) | (fl << 7);
  endfunction

  function automatic logic [31:0] modelRead(logic [7:0] a);
    case (a)
      8'h00:   return 32'(ctrlWord(mPs, mSel, mIe, mFlag));
      8'h04:   return 32'(mCnt);
      8'h08:   return 32'(mMod);
      8'h4C:   return 32'(mInit);
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mCnt = 0; mMod = 16'hFFFF; mInit = 0; mPs = 0; mSel = 0;
      mIe = 0; mFlag = 0; mArm = 0; mDiv = 0;
    end else begin
      bit src, tick, wrap, clr, wrCtl;
      int oldInit;
      oldInit = mInit;
      wrCtl = busWrEn && busAddr == 8'h00;
      src = (mSel == 1) || (mSel == 2 && fixedTickEn);
      tick = 0; wrap = 0;
      if (mSel == 0 || mSel == 3) mDiv = 0;
      else if (src) begin
        if (mDiv + 1 >= (1 << mPs)) begin tick = 1; mDiv = 0; end
        else mDiv = mDiv + 1;
      end
      if (wrCtl && int'(busWdata[2:0]) != mPs) mDiv = 0;
      if (busWrEn && busAddr == 8'h04) mCnt = oldInit;
      else if (tick) begin
        if (mCnt == mMod || mCnt == 16'hFFFF) begin mCnt = oldInit; wrap = 1; end
        else mCnt = mCnt + 1;
      end
      if (busWrEn && busAddr == 8'h08) mMod = int'(busWdata[15:0]);
      if (busWrEn && busAddr == 8'h4C) mInit = int'(busWdata[15:0]);
      clr = wrCtl && mArm && !busWdata[7];
      if (wrCtl) begin
        mPs = int'(busWdata[2:0]); mSel = int'(busWdata[4:3]); mIe = int'(busWdata[6]);
      end
      if (wrCtl) mArm = 0;
      else if (busRdEn && busAddr == 8'h00 && mFlag) mArm = 1;
      mFlag = (wrap || (mFlag && !clr)) ? 1 : 0;
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // R8: interrupt compared with the model every clock
  always @(negedge clk) if (rstN) check("R8 irq", {31'b0, irq}, 32'(mFlag & mIe));

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWrEn = 1'b1; busRdEn = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, string tag);
    @(negedge clk);
    busAddr = a; busRdEn = 1'b1; busWrEn = 1'b0;
    #1 check(tag, busRdata, modelRead(a));
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      busWrEn = 1'b0; busRdEn = 1'b0;
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset values against constants
    rd(8'h00, "R1 status"); check("R1 status const", busRdata, 32'h0);
    rd(8'h04, "R1 count");  check("R1 count const", busRdata, 32'h0);
    rd(8'h08, "R1 modulo"); check("R1 modulo const", busRdata, 32'h0000FFFF);
    rd(8'h4C, "R1 init");
    check("R1 irq", {31'b0, irq}, 32'h0);
    // R11 unmapped offsets
    wr(8'h10, 32'hFFFFFFFF); wr(8'h50, 32'h12345678);
    rd(8'h10, "R11 unmapped"); check("R11 unmapped const", busRdata, 32'h0);
    rd(8'h08, "R11 modulo untouched");
    // R5 upper bits ignored
    wr(8'h08, 32'hABCD0004);
    rd(8'h08, "R5 modulo"); check("R5 modulo const", busRdata, 32'h00000004);
    // R2 R3 R4: count every clock, modulo 4
    wr(8'h4C, 32'h0);
    wr(8'h00, 32'(ctrlWord(0, 1, 0, 0)));
    wr(8'h04, 32'hDEAD5555);
    rd(8'h04, "R4 reload ignores data");
    check("R4 reload const", busRdata, 32'h0);
    idle(2); rd(8'h04, "R2 increment");
    idle(1); rd(8'h04, "R2 wrap to init");
    rd(8'h00, "R3 flag after N ticks");
    idle(7);
    // R9 clear rules, counter stopped
    wr(8'h00, 32'(ctrlWord(0, 0, 0, 0)));
    wr(8'h00, 32'(ctrlWord(0, 0, 0, 0)));
    rd(8'h00, "R9 write zero without read");
    check("R9 still set", busRdata[7], 32'h1);
    wr(8'h00, 32'(ctrlWord(0, 0, 0, 1)));
    rd(8'h00, "R9 write one no effect");
    wr(8'h00, 32'(ctrlWord(0, 0, 0, 0)));
    rd(8'h00, "R9 proper clear");
    check("R9 cleared", busRdata[7], 32'h0);
    // R8 irq enable with flag
    wr(8'h00, 32'(ctrlWord(0, 1, 1, 0)));
    idle(12); rd(8'h00, "R8 flag with enable");
    check("R8 irq high", {31'b0, irq}, 32'h1);
    // R10 clear on the same edge as a new overflow
    wr(8'h04, 32'h0);
    idle(2);
    rd(8'h00, "R10 arm");
    idle(1);
    wr(8'h00, 32'(ctrlWord(0, 1, 1, 0)));
    rd(8'h00, "R10 flag kept");
    check("R10 flag kept const", busRdata[7], 32'h1);
    // R6 prescaler, with a mid-run field change
    wr(8'h08, 32'hFFFF);
    wr(8'h00, 32'(ctrlWord(3, 1, 0, 0)));
    wr(8'h04, 32'h0);
    idle(40); rd(8'h04, "R6 divide by 8");
    wr(8'h00, 32'(ctrlWord(5, 1, 0, 0)));
    idle(100); rd(8'h04, "R6 divide by 32 after change");
    wr(8'h00, 32'(ctrlWord(0, 1, 0, 0)));
    idle(3); rd(8'h04, "R6 divide by 1");
    // R7 source select
    wr(8'h00, 32'(ctrlWord(1, 2, 0, 0)));
    idle(50); rd(8'h04, "R7 fixed tick source");
    wr(8'h00, 32'(ctrlWord(1, 3, 0, 0)));
    rd(8'h04, "R7 halted a");
    idle(20); rd(8'h04, "R7 halted b");
    wr(8'h00, 32'(ctrlWord(1, 0, 0, 0)));
    idle(20); rd(8'h04, "R7 off");
    // R12 initial value above modulo
    wr(8'h08, 32'h0010);
    wr(8'h4C, 32'hFFF0);
    wr(8'h00, 32'(ctrlWord(0, 1, 1, 0)));
    wr(8'h04, 32'h0);
    idle(14); rd(8'h04, "R12 near top");
    idle(2); rd(8'h04, "R12 wrapped to init");
    rd(8'h00, "R12 flag");
    idle(40); rd(8'h04, "R12 second lap");
    idle(5);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule